// File: doc/BRIEF.md
# P-Persistent Channel Access Sequencer

This block decides when a half-duplex packet radio channel may be keyed. A framer raises a frame-pending request. The block then makes a p-persistence draw against a pseudo-random byte and checks carrier detect. If either test fails, it waits one slot time and tries again. If both pass, it turns the receiver off, waits a short settling period, and raises request-to-send. Once the keying delay has elapsed it tells the framer to send.

When the framer reports the end of a frame and has another frame queued, the key stays up and the keying delay is not repeated. When the end of a frame arrives with nothing queued, the key drops at once. The receiver stays off for a squelch-tail hold and is then enabled again.

All waits are counted in ticks of a parameterised clock divider. The divider default gives a 10 ms tick at 50 MHz. Four 8-bit timing parameters are held in a small register port that can be written and read back. Bit-level framing, CRC and modem clocking are handled elsewhere.

Top module: `pp_access_ctrl`

## Requirements
- R1: After reset, rts_o=0, tx_go_o=0 and rx_en_o=1. The parameter registers read back key-up delay=25 (address 0), persistence=64 (address 1), slot time=10 (address 2) and tail hold=20 (address 3).
- R2: A write (cfg_we_i high at a clock edge) stores cfg_wdata_i at cfg_addr_i. cfg_rdata_o shows the addressed register combinationally. A wait uses the register value present in the cycle the wait begins, so a write made during a wait applies only to later waits.
- R3: The random byte is the low 8 bits of a 16-bit Fibonacci LFSR. The LFSR is seeded to 16'hACE1 at reset and steps on every clock: the new bit 0 is bit15^bit13^bit12^bit10, and the register shifts left. A frame-pending request in the idle state leads to one decision cycle. In that cycle, access is granted only when the random byte is less than or equal to the persistence register and carrier_i is low.
- R4: If carrier_i is high in the decision cycle, the block goes into a slot wait and the frame is kept. rts_o stays low, and the decision is made again after the wait.
- R5: A wait of N ticks lasts N*TICK_DIV+1 clock cycles, counted from the cycle the wait state is entered. A failed decision leads to a slot wait of N = the slot register. The decision cycle follows it.
- R6: After a granted decision, rx_en_o goes low and rts_o stays low for a settling wait of N = SETTLE_TICKS. rts_o then rises.
- R7: While rts_o is high, tx_go_o stays low for a wait of N = the key-up delay register. tx_go_o then rises and stays high while the frame is sent.
- R8: frame_done_i while tx_go_o is high, with frame_pend_i also high, keeps both rts_o and tx_go_o high. No new key-up delay is inserted.
- R9: frame_done_i while tx_go_o is high, with frame_pend_i low, drops rts_o and tx_go_o in the next cycle. rx_en_o stays low for a wait of N = the tail hold register and then returns high.
- R10: With frame_pend_i low, the block stays idle. frame_done_i has no effect outside sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_pend_i | input | 1 | Framer has a frame queued |
| frame_done_i | input | 1 | One-cycle pulse marking the end of the current frame |
| carrier_i | input | 1 | Carrier detected on the channel |
| cfg_we_i | input | 1 | Parameter write strobe |
| cfg_addr_i | input | 2 | Parameter select: 0 key-up delay, 1 persistence, 2 slot time, 3 tail hold |
| cfg_wdata_i | input | 8 | Parameter write data |
| cfg_rdata_o | output | 8 | Read-back of the addressed parameter |
| rts_o | output | 1 | Transmitter key (request-to-send) |
| tx_go_o | output | 1 | Framer may send data |
| rx_en_o | output | 1 | Receive path enabled |

## Verification
The assertions assume that the framer keeps frame_pend_i high from its request until sending starts. They also assume that frame_done_i is pulsed only while tx_go_o is high, and that frame_pend_i at that pulse tells whether a further frame follows. The stimulus follows these rules for every transmitted frame. The one exception is a deliberate frame_done_i pulse in the idle state, used to check that it is ignored. That pulse is not covered by any assertion, and its effect is checked only at the ports. Carrier is raised and dropped only between stimulus steps. This way, every decision cycle sees a settled value.

// File: rtl/cac_pkg.sv
package cac_pkg;
  localparam int unsigned PAR_W  = 8;
  localparam int unsigned N_PAR  = 4;
  localparam int unsigned PAR_AW = $clog2(N_PAR);

  localparam logic [PAR_AW-1:0] PAR_KEYDLY  = 2'd0;
  localparam logic [PAR_AW-1:0] PAR_PERSIST = 2'd1;
  localparam logic [PAR_AW-1:0] PAR_SLOT    = 2'd2;
  localparam logic [PAR_AW-1:0] PAR_HOLD    = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_SLOT,
    ST_SETTLE,
    ST_KEY,
    ST_SEND,
    ST_TAIL
  } acc_state_e;
endpackage

// File: rtl/cac_regs.sv
module cac_regs
  import cac_pkg::*;
#(
  parameter int unsigned DW          = PAR_W,
  parameter int unsigned DEF_KEYDLY  = 25,
  parameter int unsigned DEF_PERSIST = 64,
  parameter int unsigned DEF_SLOT    = 10,
  parameter int unsigned DEF_HOLD    = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAR_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     keydly_o,
  output logic [DW-1:0]     persist_o,
  output logic [DW-1:0]     slot_o,
  output logic [DW-1:0]     hold_o
);
  logic [DW-1:0] q [N_PAR];

  for (genvar g = 0; g < N_PAR; g++) begin : g_par
    localparam logic [DW-1:0] DV = (g == 0) ? DW'(DEF_KEYDLY)  :
                                   (g == 1) ? DW'(DEF_PERSIST) :
                                   (g == 2) ? DW'(DEF_SLOT)    : DW'(DEF_HOLD);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q[g] <= DV;
      else if (we_i && addr_i == PAR_AW'(g))  q[g] <= wdata_i;
    end
  end

  assign rdata_o   = q[addr_i];
  assign keydly_o  = q[PAR_KEYDLY];
  assign persist_o = q[PAR_PERSIST];
  assign slot_o    = q[PAR_SLOT];
  assign hold_o    = q[PAR_HOLD];

  // R2: a write is visible at its address after the edge
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/cac_lfsr.sv
module cac_lfsr #(
  parameter int unsigned      W    = 16,
  parameter logic [W-1:0]     SEED = 16'hACE1,
  parameter logic [W-1:0]     TAPS = 16'hB400,
  parameter int unsigned      OW   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [OW-1:0] rnd_o
);
  logic [W-1:0] lfsr_q;
  logic         fb;

  assign fb = ^(lfsr_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[W-2:0], fb};
  end

  assign rnd_o = lfsr_q[OW-1:0];

  // R3: a maximal sequence never reaches the all-zero lock-up state
  a_r3_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/cac_timer.sv
module cac_timer #(
  parameter int unsigned DIV = 500000,
  parameter int unsigned CW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] target_i,
  output logic          done_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] ticks_q, tgt_q;
  logic          tick;

  assign tick   = (DIV == 1) ? 1'b1 : (pre_q == PW'(DIV - 1));
  assign done_o = (ticks_q == tgt_q);

  // prescaler restarts on every load so each wait has an exact length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      ticks_q <= '0;
      tgt_q   <= '0;
    end else if (load_i) begin
      pre_q   <= '0;
      ticks_q <= '0;
      tgt_q   <= target_i;
    end else if (!done_o) begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick) ticks_q <= ticks_q + CW'(1);
    end
  end

  // R5: the tick count never passes the latched target
  a_r5_ticks_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticks_q <= tgt_q);
endmodule

// File: rtl/pp_access_ctrl.sv
module pp_access_ctrl
  import cac_pkg::*;
#(
  parameter int unsigned        TICK_DIV     = 500000,
  parameter int unsigned        SETTLE_TICKS = 1,
  parameter int unsigned        LFSR_W       = 16,
  parameter logic [LFSR_W-1:0]  LFSR_SEED    = 16'hACE1,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS    = 16'hB400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pend_i,
  input  logic              frame_done_i,
  input  logic              carrier_i,
  input  logic              cfg_we_i,
  input  logic [PAR_AW-1:0] cfg_addr_i,
  input  logic [PAR_W-1:0]  cfg_wdata_i,
  output logic [PAR_W-1:0]  cfg_rdata_o,
  output logic              rts_o,
  output logic              tx_go_o,
  output logic              rx_en_o
);
  localparam logic [PAR_W-1:0] SETTLE_N = PAR_W'(SETTLE_TICKS);

  acc_state_e       state_q, state_d;
  logic [PAR_W-1:0] keydly, persist, slot, hold, rnd;
  logic             tmr_load, tmr_done;
  logic [PAR_W-1:0] tmr_tgt;

  cac_regs #(.DW(PAR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .keydly_o (keydly),
    .persist_o(persist),
    .slot_o   (slot),
    .hold_o   (hold)
  );

  cac_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS), .OW(PAR_W)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (rnd)
  );

  cac_timer #(.DIV(TICK_DIV), .CW(PAR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .target_i(tmr_tgt),
    .done_o  (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_tgt  = '0;
    unique case (state_q)
      ST_IDLE: if (frame_pend_i) state_d = ST_ARB;
      ST_ARB: begin
        tmr_load = 1'b1;
        if (carrier_i || rnd > persist) begin
          state_d = ST_SLOT;
          tmr_tgt = slot;
        end else begin
          state_d = ST_SETTLE;
          tmr_tgt = SETTLE_N;
        end
      end
      ST_SLOT: if (tmr_done) state_d = ST_ARB;
      ST_SETTLE: if (tmr_done) begin
        state_d  = ST_KEY;
        tmr_load = 1'b1;
        tmr_tgt  = keydly;
      end
      ST_KEY: if (tmr_done) state_d = ST_SEND;
      ST_SEND: if (frame_done_i && !frame_pend_i) begin
        state_d  = ST_TAIL;
        tmr_load = 1'b1;
        tmr_tgt  = hold;
      end
      ST_TAIL: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rts_o   = (state_q == ST_KEY) || (state_q == ST_SEND);
  assign tx_go_o = (state_q == ST_SEND);
  assign rx_en_o = (state_q == ST_IDLE) || (state_q == ST_ARB) || (state_q == ST_SLOT);

  a_r3_persist_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARB && !carrier_i && rnd <= persist) |=> (state_q == ST_SETTLE && !rx_en_o));

  a_r4_carrier_defers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARB && carrier_i) |=> (state_q == ST_SLOT && !rts_o));

  a_r6_key_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> ($past(state_q) == ST_SETTLE));

  a_r7_go_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_go_o) |-> $past(rts_o));

  a_r8_b2b_keeps_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_go_o && frame_done_i && frame_pend_i) |=> (tx_go_o && rts_o));

  a_r9_tail_rx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rts_o) |-> (!rx_en_o && !tx_go_o));

  a_r10_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !frame_pend_i) |=> (state_q == ST_IDLE));
endmodule

// File: tb/sim_pp_access_ctrl.sv
module sim_pp_access_ctrl;
  localparam int DIV    = 4;
  localparam int SETTLE = 1;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pend = 1'b0, done = 1'b0, carrier = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rts, go, rxen;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  pp_access_ctrl #(.TICK_DIV(DIV), .SETTLE_TICKS(SETTLE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_pend_i(pend), .frame_done_i(done),
    .carrier_i(carrier), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .rts_o(rts), .tx_go_o(go), .rx_en_o(rxen)
  );

  // behavioural reference: 0 idle,1 decide,2 slot,3 settle,4 key,5 send,6 tail
  int          m_st, m_cnt, m_lim, nst;
  logic [15:0] m_lfsr;
  logic [7:0]  m_reg [4];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_lim = 0; m_lfsr = 16'hACE1;
      m_reg[0] = 8'd25; m_reg[1] = 8'd64; m_reg[2] = 8'd10; m_reg[3] = 8'd20;
    end else begin
      nst = m_st;
      case (m_st)
        0: if (pend) nst = 1;
        1: begin
          m_cnt = 0;
          if (carrier || m_lfsr[7:0] > m_reg[1]) begin nst = 2; m_lim = int'(m_reg[2]) * DIV; end
          else begin nst = 3; m_lim = SETTLE * DIV; end
        end
        2, 3, 4, 6: begin
          if (m_cnt == m_lim) begin
            if (m_st == 2) nst = 1;
            else if (m_st == 3) begin nst = 4; m_cnt = 0; m_lim = int'(m_reg[0]) * DIV; end
            else if (m_st == 4) nst = 5;
            else nst = 0;
          end else m_cnt++;
        end
        5: if (done && !pend) begin nst = 6; m_cnt = 0; m_lim = int'(m_reg[3]) * DIV; end
        default: nst = 0;
      endcase
      m_st = nst;
      if (we) m_reg[addr] = wdata;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s, input logic car);
    case (s)
      0: return "R10";
      1: return car ? "R4" : "R3";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      chk({tag_of(m_st, carrier), " rts"}, int'(rts), int'(m_st == 4 || m_st == 5));
      chk({tag_of(m_st, carrier), " go"},  int'(go),  int'(m_st == 5));
      chk({tag_of(m_st, carrier), " rxen"}, int'(rxen), int'(m_st <= 2));
      chk("R2 rdata", int'(rdata), int'(m_reg[addr]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
    addr = a; #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic wait_st(input int s);
    while (m_st != s) step(1);
  endtask

  task automatic send_frames(input int n);
    pend = 1'b1;
    wait_st(5);
    for (int i = 0; i < n; i++) begin
      step(5);
      if (i == n - 1) pend = 1'b0;
      done = 1'b1;
      step(1);
      done = 1'b0;
      if (i < n - 1) chk("R8 back-to-back key held", int'(rts && go), 1);
    end
    chk("R9 key dropped", int'(rts), 0);
    chk("R9 rx held off", int'(rxen), 0);
    wait_st(0);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    chk("R1 rts", int'(rts), 0);
    chk("R1 go", int'(go), 0);
    chk("R1 rxen", int'(rxen), 1);
    rd_chk(2'd0, 25, "R1 keydly");
    rd_chk(2'd1, 64, "R1 persist");
    rd_chk(2'd2, 10, "R1 slot");
    rd_chk(2'd3, 20, "R1 hold");

    // R10: idle with no request; stray done ignored
    step(3);
    done = 1'b1; step(1); done = 1'b0;
    step(5);
    chk("R10 stays idle", int'(rts || !rxen), 0);

    // R2: shorten parameters
    wr(2'd0, 8'd3); wr(2'd1, 8'd255); wr(2'd2, 8'd2); wr(2'd3, 8'd2);
    rd_chk(2'd0, 3, "R2 keydly");
    rd_chk(2'd1, 255, "R2 persist");
    rd_chk(2'd2, 2, "R2 slot");
    rd_chk(2'd3, 2, "R2 hold");

    send_frames(1);   // R6 R7 R9
    send_frames(3);   // R8

    // R4: carrier holds off keying, frame kept
    carrier = 1'b1; pend = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step(1);
      chk("R4 no key under carrier", int'(rts), 0);
    end
    carrier = 1'b0;
    wait_st(5);
    chk("R4 frame sent after carrier", int'(go), 1);
    pend = 1'b0; done = 1'b1; step(1); done = 1'b0;
    wait_st(0);

    // R3 R5: low persistence forces slot waits
    wr(2'd1, 8'd40);
    send_frames(2);
    send_frames(1);

    // R2: write during a slot wait applies later
    wr(2'd1, 8'd0);
    pend = 1'b1;
    wait_st(2);
    wr(2'd2, 8'd1);
    wr(2'd1, 8'd255);
    wait_st(5);
    pend = 1'b0; done = 1'b1; step(1); done = 1'b0;
    wait_st(0);

    // zero-length waits
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    send_frames(2);
    step(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule